// File: doc/BRIEF.md
# DAC Power-Up and SPI Configuration Sequencer

This block brings a high-speed DAC from power-on to a configured, checked state without any processor. After a single start pulse it pulses the DAC's hardware reset line, waits for the converter to settle, and sends a fixed list of register writes over a four-wire SPI link. It then reads three status registers back and judges them. Every delay is a parameter counted in system clock cycles, so one netlist serves any clock rate once the delays are scaled.

When the script ends, `done` goes high and stays high until the next start. A two-bit code reports the first readback check that failed, or zero on success. Checking stops at the first failure, so the remaining reads are skipped. SPI uses mode 0: SCLK idles low, MOSI changes on the falling edge, MSB goes first, and MISO is captured on the rising edge.

Top module: `dac_boot_seq`

## Requirements
- R1: Out of reset, done, error and err_code are 0, spi_cs_n is 1, spi_sclk is 0 and dac_reset is 0.
- R2: A start pulse while idle or done drives dac_reset high for exactly RST_PULSE_CYC cycles, and only once per run. No SPI frame begins until at least RST_WAIT_CYC cycles after dac_reset falls.
- R3: Each frame holds 32 bits, sent MSB first. Bit 31 is 1 for a read. Bits 30:24 carry the 7-bit register address. Bits 23:16 carry the write data, which is zero on reads. Bits 15:0 are zero.
- R4: The writes go out in this order (address←data, hex): 01←01, 02←00, 03←01, 04←03, 04←0B, 05←00, 07←00, 08←08, 18←00, 19←00, 1E←00.
- R5: SPI_CS_N stays high for at least GAP_CYC cycles between two frames. It stays high for at least SOFT_WAIT_CYC cycles after the 01←01 write, and for at least PORT_WAIT_CYC cycles after the 04←03 write.
- R6: spi_cs_n stays low for the whole frame, which contains exactly 32 SCLK rising edges. SCLK is low whenever spi_cs_n is high. MOSI does not change while SCLK is high.
- R7: A read result is bits 23:16 of the 32-bit word shifted in from MISO. MISO is sampled at each SCLK rising edge. MISO values in the other bit positions have no effect on the result.
- R8: After the writes, registers 01, 02 and 03 are read in that order. Register 01 must read 0x00, or else err_code is 1. Register 02 must have bit 1 set, or else err_code is 2. Register 03 must have bit 1 set, or else err_code is 3. The first failed check ends the run, so a failing run has 11+err_code frames and a passing run has 14.
- R9: When a run ends, done is 1. err_code is 0 on success. error equals (err_code != 0). All three hold steady until the next start.
- R10: A start pulse while a run is in progress is ignored. The reset pulse does not repeat, and the frame sequence and result are the same as without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches the power-up script |
| spi_miso | input | 1 | Serial data from the DAC |
| done | output | 1 | Run finished, held until the next start |
| error | output | 1 | High when the finished run failed a check |
| err_code | output | 2 | 0 ok, 1 reset stuck, 2 clock absent, 3 data clock absent |
| dac_reset | output | 1 | Active-high hardware reset to the DAC |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to the DAC |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The hardest situation to reach is an early stop on the second or third check. The device model must return a clean soft-reset register and a healthy clock bit, and must still fail a later bit. To reach it, the bench model of the DAC serves per-run readback values: some runs are directed at each failing check, and others are random, with only bit 1 forced and random values in the other bits. Noise is also driven on MISO outside the read window, which shows that only bits 23:16 are used. A second start pulse is injected part-way through some runs to show that the script does not restart.

// File: rtl/dac_boot_pkg.sv
package dac_boot_pkg;

  localparam int FRAME_W = 32;
  localparam int NOPS    = 14;
  localparam int OP_W    = $clog2(NOPS);

  typedef enum logic [1:0] {PW_NONE, PW_SOFT, PW_PORT} post_e;
  typedef enum logic [1:0] {CK_NONE, CK_ZERO, CK_BIT1} chk_e;

  typedef struct packed {
    logic       rd;
    logic [6:0] addr;
    logic [7:0] data;
    post_e      post;
    chk_e       chk;
    logic [1:0] errc;
  } step_t;

  function automatic step_t mk(input logic rd, input logic [6:0] a, input logic [7:0] d,
                               input post_e p, input chk_e c, input logic [1:0] e);
    step_t s;
    s.rd = rd; s.addr = a; s.data = d; s.post = p; s.chk = c; s.errc = e;
    return s;
  endfunction

  // script order is behaviour: writes first, then the three checks
  function automatic step_t step_at(input logic [OP_W-1:0] i);
    case (i)
      4'd0:    return mk(1'b0, 7'h01, 8'h01, PW_SOFT, CK_NONE, 2'd0);
      4'd1:    return mk(1'b0, 7'h02, 8'h00, PW_NONE, CK_NONE, 2'd0);
      4'd2:    return mk(1'b0, 7'h03, 8'h01, PW_NONE, CK_NONE, 2'd0);
      4'd3:    return mk(1'b0, 7'h04, 8'h03, PW_PORT, CK_NONE, 2'd0);
      4'd4:    return mk(1'b0, 7'h04, 8'h0B, PW_NONE, CK_NONE, 2'd0);
      4'd5:    return mk(1'b0, 7'h05, 8'h00, PW_NONE, CK_NONE, 2'd0);
      4'd6:    return mk(1'b0, 7'h07, 8'h00, PW_NONE, CK_NONE, 2'd0);
      4'd7:    return mk(1'b0, 7'h08, 8'h08, PW_NONE, CK_NONE, 2'd0);
      4'd8:    return mk(1'b0, 7'h18, 8'h00, PW_NONE, CK_NONE, 2'd0);
      4'd9:    return mk(1'b0, 7'h19, 8'h00, PW_NONE, CK_NONE, 2'd0);
      4'd10:   return mk(1'b0, 7'h1E, 8'h00, PW_NONE, CK_NONE, 2'd0);
      4'd11:   return mk(1'b1, 7'h01, 8'h00, PW_NONE, CK_ZERO, 2'd1);
      4'd12:   return mk(1'b1, 7'h02, 8'h00, PW_NONE, CK_BIT1, 2'd2);
      4'd13:   return mk(1'b1, 7'h03, 8'h00, PW_NONE, CK_BIT1, 2'd3);
      default: return mk(1'b0, 7'h00, 8'h00, PW_NONE, CK_NONE, 2'd0);
    endcase
  endfunction

endpackage

// File: rtl/dac_boot_timer.sv
module dac_boot_timer #(
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dac_boot_spi.sv
module dac_boot_spi
  import dac_boot_pkg::*;
#(
  parameter int SCLK_HALF = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               xdone,
  output logic [FRAME_W-1:0] rx_word
);

  localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [HW-1:0] HALF_M1 = HW'(SCLK_HALF - 1);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  typedef enum logic [1:0] {SP_IDLE, SP_LO, SP_HI} sp_e;

  sp_e                st_q, st_d;
  logic [HW-1:0]      cnt_q, cnt_d;
  logic [BW-1:0]      bit_q, bit_d;
  logic [FRAME_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic               sclk_q, sclk_d, cs_q, cs_d, done_q, done_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; tx_d = tx_q; rx_d = rx_q;
    sclk_d = sclk_q; cs_d = cs_q; done_d = 1'b0;
    case (st_q)
      SP_IDLE: if (go) begin
        tx_d = frame; cs_d = 1'b0; cnt_d = '0; bit_d = '0; st_d = SP_LO;
      end
      SP_LO: if (cnt_q == HALF_M1) begin
        cnt_d = '0; sclk_d = 1'b1; rx_d = {rx_q[FRAME_W-2:0], miso}; st_d = SP_HI;
      end else cnt_d = cnt_q + 1'b1;
      SP_HI: if (cnt_q == HALF_M1) begin
        cnt_d = '0; sclk_d = 1'b0;
        if (bit_q == LAST_BIT) begin
          cs_d = 1'b1; done_d = 1'b1; st_d = SP_IDLE;
        end else begin
          bit_d = bit_q + 1'b1; tx_d = {tx_q[FRAME_W-2:0], 1'b0}; st_d = SP_LO;
        end
      end else cnt_d = cnt_q + 1'b1;
      default: st_d = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SP_IDLE; cnt_q <= '0; bit_q <= '0; tx_q <= '0; rx_q <= '0;
      sclk_q <= 1'b0; cs_q <= 1'b1; done_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d; tx_q <= tx_d; rx_q <= rx_d;
      sclk_q <= sclk_d; cs_q <= cs_d; done_q <= done_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[FRAME_W-1];
  assign cs_n    = cs_q;
  assign xdone   = done_q;
  assign rx_word = rx_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q); // R6
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(tx_q[FRAME_W-1])); // R6

endmodule

// File: rtl/dac_boot_seq.sv
module dac_boot_seq
  import dac_boot_pkg::*;
#(
  parameter int unsigned SCLK_HALF     = 4,
  parameter int unsigned RST_PULSE_CYC = 500,
  parameter int unsigned RST_WAIT_CYC  = 500000,
  parameter int unsigned SOFT_WAIT_CYC = 500000,
  parameter int unsigned PORT_WAIT_CYC = 50000,
  parameter int unsigned GAP_CYC       = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       spi_miso,
  output logic       done,
  output logic       error,
  output logic [1:0] err_code,
  output logic       dac_reset,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_cs_n
);

  localparam int unsigned M1   = (RST_PULSE_CYC > RST_WAIT_CYC) ? RST_PULSE_CYC : RST_WAIT_CYC;
  localparam int unsigned M2   = (SOFT_WAIT_CYC > PORT_WAIT_CYC) ? SOFT_WAIT_CYC : PORT_WAIT_CYC;
  localparam int unsigned M3   = (M1 > M2) ? M1 : M2;
  localparam int unsigned MAXT = (M3 > GAP_CYC) ? M3 : GAP_CYC;
  localparam int TW = $clog2(MAXT + 1);
  localparam logic [OP_W-1:0] LAST_OP = OP_W'(NOPS - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RSTH, ST_RSTW, ST_GAP, ST_XFER, ST_POST, ST_DONE} st_e;

  st_e              st_q, st_d;
  logic [OP_W-1:0]  op_q, op_d;
  logic [1:0]       err_q, err_d;
  logic             rst_q;
  logic             t_load, t_zero, go, xdone, chk_fail;
  logic [TW-1:0]    t_val;
  logic [FRAME_W-1:0] frame, rx_word;
  logic [7:0]       rd_byte;
  step_t            step;

  assign step    = step_at(op_q);
  assign frame   = {step.rd, step.addr, (step.rd ? 8'h00 : step.data), 16'h0000};
  assign rd_byte = rx_word[23:16];

  always_comb begin
    case (step.chk)
      CK_ZERO: chk_fail = (rd_byte != 8'h00);
      CK_BIT1: chk_fail = !rd_byte[1];
      default: chk_fail = 1'b0;
    endcase
  end

  always_comb begin
    st_d = st_q; op_d = op_q; err_d = err_q;
    t_load = 1'b0; t_val = '0; go = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: if (start) begin
        st_d = ST_RSTH; op_d = '0; err_d = 2'd0;
        t_load = 1'b1; t_val = TW'(RST_PULSE_CYC - 1);
      end
      ST_RSTH: if (t_zero) begin
        st_d = ST_RSTW; t_load = 1'b1; t_val = TW'(RST_WAIT_CYC - 1);
      end
      ST_RSTW: if (t_zero) begin
        st_d = ST_GAP; t_load = 1'b1; t_val = TW'(GAP_CYC - 1);
      end
      ST_GAP: if (t_zero) begin
        go = 1'b1; st_d = ST_XFER;
      end
      ST_XFER: if (xdone) begin
        if (step.rd && chk_fail) begin
          err_d = step.errc; st_d = ST_DONE;
        end else if (op_q == LAST_OP) begin
          st_d = ST_DONE;
        end else begin
          op_d = op_q + 1'b1; t_load = 1'b1;
          case (step.post)
            PW_SOFT: begin st_d = ST_POST; t_val = TW'(SOFT_WAIT_CYC - 1); end
            PW_PORT: begin st_d = ST_POST; t_val = TW'(PORT_WAIT_CYC - 1); end
            default: begin st_d = ST_GAP;  t_val = TW'(GAP_CYC - 1); end
          endcase
        end
      end
      ST_POST: if (t_zero) begin
        st_d = ST_GAP; t_load = 1'b1; t_val = TW'(GAP_CYC - 1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; op_q <= '0; err_q <= 2'd0; rst_q <= 1'b0;
    end else begin
      st_q <= st_d; op_q <= op_d; err_q <= err_d; rst_q <= (st_d == ST_RSTH);
    end
  end

  dac_boot_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  dac_boot_spi #(.SCLK_HALF(SCLK_HALF)) u_spi (
    .clk(clk), .rst_n(rst_n), .go(go), .frame(frame), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n), .xdone(xdone), .rx_word(rx_word)
  );

  assign done      = (st_q == ST_DONE);
  assign err_code  = err_q;
  assign error     = done && (err_q != 2'd0);
  assign dac_reset = rst_q;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dac_reset |-> spi_cs_n); // R2
  AST_FRAME_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> (st_q == ST_XFER)); // R5
  AST_OP_IN_SCRIPT: assert property (@(posedge clk) disable iff (!rst_n)
    op_q <= LAST_OP); // R4
  AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != 2'd0) |-> (st_q == ST_DONE)); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q != ST_IDLE && st_q != ST_DONE && st_q != ST_RSTH) |=> (st_q != ST_RSTH)); // R10

endmodule

// File: tb/sim_dac_boot_seq.sv
module sim_dac_boot_seq;

  localparam int SCLK_HALF = 2;
  localparam int T_RP = 20, T_RW = 50, T_SW = 80, T_PW = 60, T_GP = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic spi_miso, done, error, dac_reset, spi_sclk, spi_mosi, spi_cs_n;
  logic [1:0] err_code;

  always #10 clk = ~clk;

  dac_boot_seq #(.SCLK_HALF(SCLK_HALF), .RST_PULSE_CYC(T_RP), .RST_WAIT_CYC(T_RW),
                 .SOFT_WAIT_CYC(T_SW), .PORT_WAIT_CYC(T_PW), .GAP_CYC(T_GP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .spi_miso(spi_miso), .done(done),
    .error(error), .err_code(err_code), .dac_reset(dac_reset), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n));

  int nchk = 0, nerr = 0;
  int cyc = 0;
  bit wd = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) wd <= 1'b1;
  end

  // ---------------- DAC model ----------------
  logic [7:0]  rv1, rv2, rv3;
  logic [31:0] noise;
  logic [31:0] cap = '0;
  logic [7:0]  hdr = '0;
  int          bitc = 0;
  int          nfr = 0;
  logic [31:0] frames [256];
  int          fbits  [256];

  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      if (bitc != 0) begin
        frames[nfr] <= cap; fbits[nfr] <= bitc; nfr <= nfr + 1;
      end
      bitc <= 0;
    end else begin
      cap <= {cap[30:0], spi_mosi};
      if (bitc == 7) hdr <= {cap[6:0], spi_mosi};
      bitc <= bitc + 1;
    end
  end

  logic [7:0] rdval;
  always_comb begin
    case (hdr[6:0])
      7'h01:   rdval = rv1;
      7'h02:   rdval = rv2;
      7'h03:   rdval = rv3;
      default: rdval = 8'h00;
    endcase
    if (hdr[7] && bitc >= 8 && bitc < 16) spi_miso = rdval[15 - bitc];
    else                                  spi_miso = noise[31 - (bitc % 32)];
  end

  // ---------------- timing monitor ----------------
  int   tfall [256], trise [256];
  int   nfall = 0, nrise = 0, rst_total = 0, rst_rises = 0, t_rstfall = 0;
  logic prev_cs = 1'b1, prev_rst = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !spi_cs_n) begin tfall[nfall] <= cyc; nfall <= nfall + 1; end
      if (!prev_cs && spi_cs_n) begin trise[nrise] <= cyc; nrise <= nrise + 1; end
      if (dac_reset) rst_total <= rst_total + 1;
      if (dac_reset && !prev_rst) rst_rises <= rst_rises + 1;
      if (!dac_reset && prev_rst) t_rstfall <= cyc;
      prev_cs <= spi_cs_n; prev_rst <= dac_reset;
    end
  end

  // ---------------- expected values ----------------
  function automatic logic [31:0] exp_frame(input int k);
    logic [7:0] a, d; logic r;
    r = (k >= 11); d = 8'h00;
    case (k)
      0: begin a = 8'h01; d = 8'h01; end
      1: a = 8'h02;
      2: begin a = 8'h03; d = 8'h01; end
      3: begin a = 8'h04; d = 8'h03; end
      4: begin a = 8'h04; d = 8'h0B; end
      5: a = 8'h05;
      6: a = 8'h07;
      7: begin a = 8'h08; d = 8'h08; end
      8: a = 8'h18;
      9: a = 8'h19;
      10: a = 8'h1E;
      11: a = 8'h01;
      12: a = 8'h02;
      default: a = 8'h03;
    endcase
    return {r, a[6:0], d, 16'h0000};
  endfunction

  function automatic int exp_err(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    if (a != 8'h00) return 1;
    if (!b[1])      return 2;
    if (!c[1])      return 3;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                          input bit busy_kick);
    int base, rbase, rrises, e, n;
    rv1 = a; rv2 = b; rv3 = c; noise = $urandom;
    base = nfr; rbase = rst_total; rrises = rst_rises;
    e = exp_err(a, b, c);
    n = (e == 0) ? 14 : 11 + e;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    if (busy_kick) begin
      repeat (T_RP + T_RW + 200) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done && !wd) @(negedge clk);
    if (wd) return;
    chk(err_code == 2'(e), "R8", "err_code", err_code, e);
    chk(nfr - base == n, "R8", "frame count", nfr - base, n);
    chk(error == (e != 0), "R9", "error flag", error, (e != 0));
    chk(rst_total - rbase == T_RP, "R2", "reset cycles", rst_total - rbase, T_RP);
    chk(rst_rises - rrises == 1, "R10", "reset pulses", rst_rises - rrises, 1);
    chk(tfall[base] - t_rstfall >= T_RW, "R2", "reset to first frame", tfall[base] - t_rstfall, T_RW);
    for (int k = 0; k < n && k < 14; k++) begin
      chk(frames[base + k] == exp_frame(k), (k < 11) ? "R4" : "R3", "frame", frames[base + k], exp_frame(k));
      chk(fbits[base + k] == 32, "R6", "sclk edges", fbits[base + k], 32);
      if (k > 0)
        chk(tfall[base + k] - trise[base + k - 1] >= T_GP, "R5", "gap", tfall[base + k] - trise[base + k - 1], T_GP);
    end
    chk(tfall[base + 1] - trise[base] >= T_SW, "R5", "soft wait", tfall[base + 1] - trise[base], T_SW);
    chk(tfall[base + 4] - trise[base + 3] >= T_PW, "R5", "port wait", tfall[base + 4] - trise[base + 3], T_PW);
    repeat (25) @(negedge clk);
    chk(done && err_code == 2'(e) && nfr - base == n, "R9", "held after done", {done, err_code}, {1'b1, 2'(e)});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rv1 = 8'h00; rv2 = 8'h02; rv3 = 8'h02; noise = 32'h0;
    repeat (3) @(negedge clk);
    chk(!done && !error && err_code == 2'd0, "R1", "status at reset", {done, error, err_code}, 0);
    chk(spi_cs_n && !spi_sclk && !dac_reset, "R1", "pins at reset", {spi_cs_n, spi_sclk, dac_reset}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && spi_cs_n && !spi_sclk && !dac_reset, "R1", "idle after release", {done, spi_cs_n, spi_sclk, dac_reset}, 4'b0100);
    // directed: pass, each failure, busy start; R7 by MISO noise outside read window
    run_case(8'h00, 8'h02, 8'h03, 1'b0);
    run_case(8'h01, 8'hFF, 8'hFF, 1'b0);
    run_case(8'h00, 8'hFD, 8'hFF, 1'b0);
    run_case(8'h00, 8'h02, 8'h01, 1'b1);
    run_case(8'h00, 8'hFF, 8'hFE, 1'b1);
    for (int i = 0; i < 6 && !wd; i++) begin
      logic [7:0] a, b, c;
      a = ($urandom % 4 == 0) ? 8'(($urandom % 255) + 1) : 8'h00;
      b = (8'($urandom) & 8'hFD) | (($urandom % 4 != 0) ? 8'h02 : 8'h00);
      c = (8'($urandom) & 8'hFD) | (($urandom % 4 != 0) ? 8'h02 : 8'h00);
      run_case(a, b, c, bit'($urandom % 2));
    end
    if (wd) chk(1'b0, "R9", "watchdog expired", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule